// File: doc/BRIEF.md
# SD Card Clock Divider and Startup Sequencer

This block derives the clock sent to an SD card from a faster base clock. Software programs it through one 16-bit control word. The word carries a 10-bit divide value, which is split across two fields. It also carries an internal-clock enable, a PLL enable and a card-clock enable. A stable indication is returned through the same word and cannot be written.

When the internal clock is switched on, or the PLL is switched on, a fixed settling interval runs before the stable indication appears. The card clock is released only when card-clock enable and stable are both set. Software picks the divide value from the base clock frequency so that the card clock stays at or under 400 kHz while the card is being identified.

A divide value N greater than zero gives a card clock of base/(2N) with equal high and low phases. N = 0 passes the base clock straight through. A compatibility input limits the divider to power-of-two divisors of at most 256, as older controllers require. A new divide value, or a change of the compatibility input, takes effect only at a falling edge of the card clock, so no shortened pulse is produced.

Top module: `sdclk_gen`

## Requirements
- R1: After reset the control word reads 0x0000 and the card clock is low.
- R2: The control word layout is as follows. Divide bits 7:0 are at word bits 15:8, and divide bits 9:8 are at word bits 7:6. Internal enable is bit 0, stable is bit 1, card enable is bit 2 and PLL enable is bit 3. Bits 5:4 read 0. A written value of bit 1 is ignored.
- R3: Stable reads 1 exactly STAB_CYCLES base-clock cycles after the clock edge that sets internal enable, and reads 0 before that.
- R4: Clearing internal enable makes stable read 0 at the first read after the write edge.
- R5: Setting PLL enable while the internal clock is enabled makes stable drop, and stable returns STAB_CYCLES cycles later.
- R6: The card clock stays low in both base-clock phases while card enable is clear or stable is low.
- R7: For an effective divide value N > 0, the card clock is high for N base cycles and low for N base cycles.
- R8: With N = 0 the card clock follows the base clock: it is high in the high phase and low in the low phase.
- R9: A divide value written while the card clock runs takes effect at the next falling edge of the card clock. The high phase in progress keeps its old length.
- R10: With compat_pow2_i = 1, the effective N is the highest set bit of the divide value, capped at 128 (divide by 256). A divide value of 0 still means pass-through.
- R11: With compat_pow2_i = 0, the full 10-bit divide value is used, including values above 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base_i | input | 1 | Base clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| compat_pow2_i | input | 1 | 1 limits the divider to power-of-two divisors of at most 256 |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 16 | Control word write data |
| rd_data_o | output | 16 | Control word read data, including the stable flag |
| card_clk_o | output | 1 | Divided or passed-through card clock |

## Verification
The assertions assume that wr_en_i, wr_data_i and compat_pow2_i change only away from the rising base-clock edge. They also assume that the control word is the only way the enables change. The bench therefore drives all inputs just after a falling or rising edge and samples the card clock 1 ns after each edge. Random divide values stay in 1..40, or anywhere in 1..1023 when compatibility mode is on, so that each measured period fits well inside the run. A directed 300 checks the wide path without compatibility mode.

// File: rtl/sdclk_pkg.sv
`timescale 1ns/1ps
package sdclk_pkg;
    localparam int DIV_W    = 10;
    localparam int LO_W     = 8;
    localparam int HI_W     = DIV_W - LO_W;
    localparam int WORD_W   = 16;
    // control word bit positions
    localparam int B_IEN    = 0;
    localparam int B_STB    = 1;
    localparam int B_CEN    = 2;
    localparam int B_PLL    = 3;
    localparam int HI_LSB   = 6;
    localparam int LO_LSB   = 8;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             pll;
        logic             cen;
        logic             ien;
    } ctrl_t;
endpackage

// File: rtl/sdclk_ctrl_reg.sv
`timescale 1ns/1ps
module sdclk_ctrl_reg
    import sdclk_pkg::*;
#(
    parameter int STAB_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output ctrl_t             ctrl_o,
    output logic              stable_o
);
    localparam int CNT_W = $clog2(STAB_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STAB_CYCLES - 1);

    typedef struct packed {
        ctrl_t            ctrl;
        logic             stable;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.ctrl.ien = wr_data[B_IEN];
            s_d.ctrl.cen = wr_data[B_CEN];
            s_d.ctrl.pll = wr_data[B_PLL];
            s_d.ctrl.div = {wr_data[HI_LSB +: HI_W], wr_data[LO_LSB +: LO_W]};
        end
        if (!s_d.ctrl.ien) begin
            s_d.stable = 1'b0;
            s_d.cnt    = '0;
        end else if (!s_q.ctrl.ien || (s_d.ctrl.pll && !s_q.ctrl.pll)) begin
            // fresh enable or PLL start: settle again
            s_d.stable = 1'b0;
            s_d.cnt    = '0;
        end else if (!s_q.stable) begin
            if (s_q.cnt == CNT_LAST) begin
                s_d.stable = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl_o   = s_q.ctrl;
    assign stable_o = s_q.stable;

    AST_STABLE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.stable |-> s_q.ctrl.ien);                                   // R4
    AST_STABLE_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.stable) |-> ($past(s_q.cnt) == CNT_LAST));             // R3
    AST_EN_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[B_IEN]) |=> !s_q.stable);                     // R4
    AST_PLL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[B_IEN] && wr_data[B_PLL] && !s_q.ctrl.pll && s_q.ctrl.ien)
        |=> !s_q.stable);                                                // R5
endmodule

// File: rtl/sdclk_div_map.sv
`timescale 1ns/1ps
module sdclk_div_map
    import sdclk_pkg::*;
#(
    parameter int MAX_LOG = 7
) (
    input  logic [DIV_W-1:0] div_i,
    input  logic             compat_i,
    output logic [DIV_W-1:0] eff_o
);
    logic [DIV_W-1:0] pow2;

    // highest set bit, clamped at 2**MAX_LOG
    always_comb begin
        pow2 = '0;
        for (int i = 0; i < DIV_W; i++) begin
            if (div_i[i]) begin
                pow2 = (i > MAX_LOG) ? (DIV_W'(1) << MAX_LOG) : (DIV_W'(1) << i);
            end
        end
    end

    assign eff_o = compat_i ? pow2 : div_i;
endmodule

// File: rtl/sdclk_divider.sv
`timescale 1ns/1ps
module sdclk_divider
    import sdclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] eff_i,
    output logic             card_clk_o
);
    typedef struct packed {
        logic [DIV_W-1:0] act;
        logic [DIV_W-1:0] cnt;
        logic             tog;
    } st_t;

    st_t  s_d, s_q;
    logic pass_gate_q;

    always_comb begin
        s_d = s_q;
        if (!run_i || (s_q.act == '0)) begin
            // idle or pass-through: free to pick up a new value
            s_d.tog = 1'b0;
            s_d.cnt = '0;
            s_d.act = eff_i;
        end else if (s_q.cnt == (s_q.act - DIV_W'(1))) begin
            s_d.cnt = '0;
            s_d.tog = !s_q.tog;
            if (s_q.tog) begin
                s_d.act = eff_i;
            end
        end else begin
            s_d.cnt = s_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // pass-through gate only moves while the base clock is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pass_gate_q <= 1'b0;
        end else begin
            pass_gate_q <= run_i && (s_q.act == '0);
        end
    end

    assign card_clk_o = (clk & pass_gate_q) | s_q.tog;

    AST_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !s_q.tog);                                            // R6
    AST_CHANGE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && s_q.act != '0) |=> ((s_q.act == $past(s_q.act)) || ($past(s_q.tog) && !s_q.tog))); // R9
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && s_q.act != '0) |-> (s_q.cnt < s_q.act));               // R7
    AST_PASS_NO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.act == '0) |-> !s_q.tog);                                   // R8
endmodule

// File: rtl/sdclk_gen.sv
`timescale 1ns/1ps
module sdclk_gen
    import sdclk_pkg::*;
#(
    parameter int STAB_CYCLES = 16,
    parameter int MAX_LOG     = 7
) (
    input  logic        clk_base_i,
    input  logic        rst_n_i,
    input  logic        compat_pow2_i,
    input  logic        wr_en_i,
    input  logic [15:0] wr_data_i,
    output logic [15:0] rd_data_o,
    output logic        card_clk_o
);
    localparam logic [DIV_W-1:0] EFF_CAP = DIV_W'(1) << MAX_LOG;

    ctrl_t            ctrl;
    logic             stable;
    logic [DIV_W-1:0] eff_n;
    logic             run;

    sdclk_ctrl_reg #(.STAB_CYCLES(STAB_CYCLES)) u_reg (
        .clk      (clk_base_i),
        .rst_n    (rst_n_i),
        .wr_en    (wr_en_i),
        .wr_data  (wr_data_i),
        .ctrl_o   (ctrl),
        .stable_o (stable)
    );

    sdclk_div_map #(.MAX_LOG(MAX_LOG)) u_map (
        .div_i    (ctrl.div),
        .compat_i (compat_pow2_i),
        .eff_o    (eff_n)
    );

    assign run = ctrl.cen && stable;

    sdclk_divider u_div (
        .clk        (clk_base_i),
        .rst_n      (rst_n_i),
        .run_i      (run),
        .eff_i      (eff_n),
        .card_clk_o (card_clk_o)
    );

    assign rd_data_o = {ctrl.div[LO_W-1:0], ctrl.div[DIV_W-1:LO_W], 2'b00,
                        ctrl.pll, ctrl.cen, stable, ctrl.ien};

    AST_COMPAT_POW2: assert property (@(posedge clk_base_i) disable iff (!rst_n_i)
        compat_pow2_i |-> (($countones(eff_n) <= 1) && (eff_n <= EFF_CAP)));  // R10
    AST_RUN_NEEDS_EN: assert property (@(posedge clk_base_i) disable iff (!rst_n_i)
        run |-> ctrl.ien);                                                     // R6
endmodule

// File: tb/sdclk_gen_tb.sv
`timescale 1ns/1ps
module sdclk_gen_tb;
    localparam int S = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        compat = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        card_clk;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    sdclk_gen #(.STAB_CYCLES(S)) u_dut (
        .clk_base_i    (clk),
        .rst_n_i       (rst_n),
        .compat_pow2_i (compat),
        .wr_en_i       (wr_en),
        .wr_data_i     (wr_data),
        .rd_data_o     (rd_data),
        .card_clk_o    (card_clk)
    );

    function automatic logic [15:0] mk(input int n, input bit pll, input bit cen, input bit ien);
        logic [9:0] d = 10'(n);
        return {d[7:0], d[9:8], 2'b00, pll, cen, 1'b0, ien};
    endfunction

    function automatic int eff(input int n, input bit c);
        int r = 0;
        if (!c) return n;
        for (int i = 0; i < 10; i++) if (n[i]) r = 1 << i;
        return (r > 128) ? 128 : r;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called between edges; write lands on next rising edge
    task automatic wr(input logic [15:0] v);
        wr_en = 1'b1;
        wr_data = v;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic tick(output logic v);
        @(negedge clk);
        #1 v = card_clk;
    endtask

    task automatic wait_fall();
        logic p, c;
        tick(p);
        for (int g = 0; g < 4000; g++) begin
            tick(c);
            if (p && !c) return;
            p = c;
        end
    endtask

    // measure the low then high phase after the second fall
    task automatic measure(input int exp_n, input string req);
        logic v;
        int lo = 1, hi = 0;
        wait_fall();
        wait_fall();
        tick(v);
        while (!v && lo < 4000) begin lo++; tick(v); end
        while (v && hi < 4000) begin hi++; tick(v); end
        chk(lo == exp_n, {req, " low phase"}, lo, exp_n);
        chk(hi == exp_n, {req, " high phase"}, hi, exp_n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic v;
        void'($urandom(32'd7731));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rd_data == 16'h0000, "R1 word", int'(rd_data), 0);
        chk(card_clk == 1'b0, "R1 clock", int'(card_clk), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R2 layout, bit 1 write ignored
        wr(16'hFFFF);
        @(negedge clk); #1;
        chk(rd_data == 16'hFFCD, "R2 readback", int'(rd_data), 'hFFCD);
        wr(16'h0000);

        // R3 settle, R6 held low before stable, with pass-through divider
        wr(mk(0, 0, 1, 1));
        for (int i = 0; i <= S; i++) begin
            @(negedge clk); #1;
            if (i == S - 1) chk(rd_data[1] == 1'b0, "R3 early", int'(rd_data[1]), 0);
            if (i == S)     chk(rd_data[1] == 1'b1, "R3 on time", int'(rd_data[1]), 1);
            if (i < S) begin
                chk(card_clk == 1'b0, "R6 low phase before stable", int'(card_clk), 0);
                @(posedge clk); #1;
                chk(card_clk == 1'b0, "R6 high phase before stable", int'(card_clk), 0);
            end
        end
        // R8 pass-through
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1;
            chk(card_clk == 1'b1, "R8 high", int'(card_clk), 1);
            @(negedge clk); #1;
            chk(card_clk == 1'b0, "R8 low", int'(card_clk), 0);
        end
        // R6 card enable cleared
        wr(mk(0, 0, 0, 1));
        repeat (2) @(posedge clk);
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1;
            chk(card_clk == 1'b0, "R6 cen clear high phase", int'(card_clk), 0);
            @(negedge clk); #1;
            chk(card_clk == 1'b0, "R6 cen clear low phase", int'(card_clk), 0);
        end
        // R5 PLL restarts settling
        @(negedge clk); #1;
        wr(mk(0, 1, 0, 1));
        for (int i = 0; i <= S; i++) begin
            @(negedge clk); #1;
            if (i == 0)     chk(rd_data[1] == 1'b0, "R5 drop", int'(rd_data[1]), 0);
            if (i == S - 1) chk(rd_data[1] == 1'b0, "R5 early", int'(rd_data[1]), 0);
            if (i == S)     chk(rd_data[1] == 1'b1, "R5 return", int'(rd_data[1]), 1);
        end
        // R4 disable clears stable
        wr(mk(0, 1, 0, 0));
        @(negedge clk); #1;
        chk(rd_data[1] == 1'b0, "R4 stable cleared", int'(rd_data[1]), 0);

        // R7 divided clock
        wr(mk(3, 1, 1, 1));
        repeat (S + 2) @(posedge clk);
        measure(3, "R7 n=3");
        // R11 wide value
        #1 wr(mk(300, 1, 1, 1));
        measure(300, "R11 n=300");
        // R10 compatibility directed
        compat = 1'b1;
        #1 wr(mk(5, 1, 1, 1));
        measure(4, "R10 n=5");
        #1 wr(mk(200, 1, 1, 1));
        measure(128, "R10 n=200");
        compat = 1'b0;

        // R9 change during high phase
        #1 wr(mk(4, 1, 1, 1));
        wait_fall();
        begin
            logic p = 1'b0;
            int hi = 0, lo = 0;
            while (1) begin tick(v); if (!p && v) break; p = v; end
            hi = 1;
            wr(mk(10, 1, 1, 1));
            tick(v);
            while (v && hi < 4000) begin hi++; tick(v); end
            while (!v && lo < 4000) begin lo++; tick(v); end
            chk(hi == 4, "R9 old high phase kept", hi, 4);
            chk(lo == 10, "R9 new low phase", lo, 10);
        end

        // random mix (R7, R10)
        for (int it = 0; it < 10; it++) begin
            bit c = 1'($urandom_range(0, 1));
            int n = c ? int'($urandom_range(1, 1023)) : int'($urandom_range(1, 40));
            compat = c;
            #1 wr(mk(n, 1, 1, 1));
            measure(eff(n, c), c ? "R10 random" : "R7 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule